// File: doc/BRIEF.md
# Serial Input Frame Builder for a Codec Link

This block is the codec-side transmitter of the input direction of an AC-link style serial audio link. On each rising edge of the frame sync it takes a snapshot of everything that should travel to the controller in the coming frame: a codec-ready flag, the latest register read response (7-bit index plus 16-bit data), and one left and one right 18-bit record sample. It builds the tag slot, packs the twelve 20-bit data slots with their fixed zero fields, and shifts the resulting 256-bit frame out MSB first, one bit per bit clock.

Each producer raises its valid flag for one or more bit clocks. A value that arrives while a frame is being shifted is kept in a one-entry holding register and goes into the next frame. The holding register is cleared when a frame takes it, so each response or sample travels once unless the producer sends it again. The serial output changes only on the rising bit-clock edge, which leaves a full half period for the receiver to sample on the falling edge.

Top module: `acin_frame_tx`

## Requirements
- R1: A frame is 256 bits: a 16-bit tag slot, then data slots 1 to 12 of 20 bits each, every field MSB first. The bit clock edge that sees `sync` high after it was low loads the frame, and frame bit 255 appears on `sdata` after the next rising edge.
- R2: Tag slot bit 15 is `codec_ready` as sampled at the load edge. Bits 14 and 13 (slots 1 and 2) are both set when a read response is present. Bit 12 (slot 3) is set when a left sample is present and bit 11 (slot 4) when a right sample is present. Bits 10:0 are 0.
- R3: Slot 1 is `{1'b0, index[6:0], 12'b0}` and slot 2 is `{data[15:0], 4'b0}`. When no read response is present, both slots are all zeros.
- R4: Slot 3 is `{left[17:0], 2'b0}` and slot 4 is `{right[17:0], 2'b0}`. A slot whose sample is absent is all zeros.
- R5: Slots 5 through 12 (frame bits 159:0) are always 0.
- R6: Inputs that change while a frame is being shifted do not alter that frame. A valid pulse of a single bit clock during a frame is held and delivered in the next frame. It is cleared once taken, so the frame after that shows its tag as 0 unless the input was sent again.
- R7: After bit 0 of a frame has been sent, and until the next sync rising edge, `sdata` is 0.
- R8: While reset is asserted and after it is released, `sdata` is 0. Reset also discards any held response or sample.
- R9: Only a low-to-high change of `sync` starts a frame. Holding `sync` high does not start another frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sync | input | 1 | Frame sync; a rising level starts a frame |
| codec_ready | input | 1 | Ready flag placed in tag bit 15 |
| rd_valid | input | 1 | Read response present on `rd_idx` and `rd_data` |
| rd_idx | input | 7 | Index of the register being read back |
| rd_data | input | 16 | Read data of that register |
| rec_l_valid | input | 1 | Left record sample present |
| rec_l | input | 18 | Left record sample |
| rec_r_valid | input | 1 | Right record sample present |
| rec_r | input | 18 | Right record sample |
| sdata | output | 1 | Serial input-frame data, MSB first |

## Verification
The bench uses all-ones index, data and samples. A design that let sample bits into the two pad positions, or shifted the index by one bit, would show non-zero bits where zeros are required. It presents a response and samples with their valid flags low but nonzero data, so that a design gating only the tag and not the slot would leak stale data into slots 1 to 4. It injects a one-cycle valid pulse in the middle of a frame and checks three frames in a row. A design without holding would lose the pulse, a design without a snapshot would corrupt the running frame, and a design that never clears the holding register would repeat the value. Holding sync high past the frame end, idling after the last bit, and a reset that lands on a held value test the start detection, the idle level and the reset flush.

// File: rtl/acin_pkg.sv
package acin_pkg;
  // Default geometry of the input frame.
  localparam int unsigned TAG_W_D  = 16;
  localparam int unsigned SLOT_W_D = 20;
  localparam int unsigned NSLOT_D  = 12;
  localparam int unsigned IDX_W_D  = 7;
  localparam int unsigned RD_W_D   = 16;
  localparam int unsigned ADC_W_D  = 18;

  // Number of slots that can ever carry payload (index, data, left, right).
  localparam int unsigned NDATA    = 4;

  function automatic int unsigned frame_bits(input int unsigned tag_w,
                                             input int unsigned slot_w,
                                             input int unsigned nslot);
    return tag_w + slot_w * nslot;
  endfunction
endpackage

// File: rtl/acin_hold.sv
module acin_hold #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_v,
  input  logic [W-1:0] in_d,
  input  logic         take,
  output logic         eff_v,
  output logic [W-1:0] eff_d
);
  logic         pend_v, pend_v_n;
  logic [W-1:0] pend_d, pend_d_n;
  logic         ld_en;

  // A value offered in the take cycle goes straight into the frame.
  assign eff_v = in_v | pend_v;
  assign eff_d = in_v ? in_d : pend_d;

  always_comb begin
    ld_en    = in_v & ~take;
    pend_d_n = pend_d;
    if (ld_en) pend_d_n = in_d;
    if (take)       pend_v_n = 1'b0;
    else if (in_v)  pend_v_n = 1'b1;
    else            pend_v_n = pend_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v <= 1'b0;
      pend_d <= '0;
    end else begin
      pend_v <= pend_v_n;
      if (ld_en) pend_d <= pend_d_n;
    end
  end

  // R6: nothing offered and nothing taken leaves the held value alone
  p_hold_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_v && !take) |=> ($stable(pend_v) && $stable(pend_d)));
  // R6: a take always empties the holding register
  p_hold_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !pend_v);
endmodule

// File: rtl/acin_frame_pack.sv
module acin_frame_pack
  import acin_pkg::*;
#(
  parameter int unsigned TAG_W  = TAG_W_D,
  parameter int unsigned SLOT_W = SLOT_W_D,
  parameter int unsigned NSLOT  = NSLOT_D,
  parameter int unsigned IDX_W  = IDX_W_D,
  parameter int unsigned RD_W   = RD_W_D,
  parameter int unsigned ADC_W  = ADC_W_D,
  localparam int unsigned FRAME_W = frame_bits(TAG_W, SLOT_W, NSLOT)
) (
  input  logic               ready_i,
  input  logic               rd_v_i,
  input  logic [IDX_W-1:0]   rd_idx_i,
  input  logic [RD_W-1:0]    rd_dat_i,
  input  logic               l_v_i,
  input  logic [ADC_W-1:0]   l_d_i,
  input  logic               r_v_i,
  input  logic [ADC_W-1:0]   r_d_i,
  output logic [FRAME_W-1:0] frame_o
);
  localparam int unsigned IDX_PAD = SLOT_W - 1 - IDX_W;
  localparam int unsigned RD_PAD  = SLOT_W - RD_W;
  localparam int unsigned ADC_PAD = SLOT_W - ADC_W;

  logic [SLOT_W-1:0] slot_q [NDATA];
  logic [TAG_W-1:0]  tag_q;

  always_comb begin
    for (int s = 0; s < NDATA; s++) slot_q[s] = '0;
    tag_q = '0;
    tag_q[TAG_W-1] = ready_i;
    if (rd_v_i) begin
      slot_q[0]      = {1'b0, rd_idx_i, {IDX_PAD{1'b0}}};
      slot_q[1]      = {rd_dat_i, {RD_PAD{1'b0}}};
      tag_q[TAG_W-2] = 1'b1;
      tag_q[TAG_W-3] = 1'b1;
    end
    if (l_v_i) begin
      slot_q[2]      = {l_d_i, {ADC_PAD{1'b0}}};
      tag_q[TAG_W-4] = 1'b1;
    end
    if (r_v_i) begin
      slot_q[3]      = {r_d_i, {ADC_PAD{1'b0}}};
      tag_q[TAG_W-5] = 1'b1;
    end
  end

  assign frame_o[FRAME_W-1 -: TAG_W] = tag_q;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    if (g < NDATA) begin : g_payload
      assign frame_o[FRAME_W-TAG_W-1-g*SLOT_W -: SLOT_W] = slot_q[g];
    end else begin : g_stuff
      assign frame_o[FRAME_W-TAG_W-1-g*SLOT_W -: SLOT_W] = '0;
    end
  end
endmodule

// File: rtl/acin_shifter.sv
module acin_shifter #(
  parameter int unsigned FRAME_W = 256,
  localparam int unsigned CNT_W  = $clog2(FRAME_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sync_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               start_o,
  output logic               sdata_o
);
  logic               sync_q;
  logic               busy, busy_n;
  logic [CNT_W-1:0]   cnt, cnt_n;
  logic [FRAME_W-1:0] shreg, shreg_n;
  logic               sdata_n;
  logic               last_bit;

  assign start_o  = sync_i & ~sync_q;
  assign last_bit = (cnt == CNT_W'(FRAME_W - 1));

  always_comb begin
    busy_n  = busy;
    cnt_n   = cnt;
    shreg_n = shreg;
    sdata_n = 1'b0;
    if (start_o) begin
      busy_n  = 1'b1;
      cnt_n   = '0;
      shreg_n = frame_i;
    end else if (busy) begin
      sdata_n = shreg[FRAME_W-1];
      shreg_n = {shreg[FRAME_W-2:0], 1'b0};
      cnt_n   = cnt + 1'b1;
      if (last_bit) busy_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 1'b0;
      busy    <= 1'b0;
      cnt     <= '0;
      shreg   <= '0;
      sdata_o <= 1'b0;
    end else begin
      sync_q  <= sync_i;
      busy    <= busy_n;
      sdata_o <= sdata_n;
      if (start_o || busy) begin
        cnt   <= cnt_n;
        shreg <= shreg_n;
      end
    end
  end

  // R1: a sync rise arms a fresh frame from bit 0
  p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> (busy && cnt == '0));
  // R7: the frame ends after its last bit unless a new sync rise comes
  p_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && last_bit && !start_o) |=> !busy);
  // R7: idle for two cycles means the line is low
  p_idle_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> !sdata_o);
  // R9: a sync level held high never restarts the frame
  p_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_i && $past(sync_i)) |-> !start_o);
endmodule

// File: rtl/acin_frame_tx.sv
module acin_frame_tx
  import acin_pkg::*;
#(
  parameter int unsigned TAG_W  = TAG_W_D,
  parameter int unsigned SLOT_W = SLOT_W_D,
  parameter int unsigned NSLOT  = NSLOT_D,
  parameter int unsigned IDX_W  = IDX_W_D,
  parameter int unsigned RD_W   = RD_W_D,
  parameter int unsigned ADC_W  = ADC_W_D
) (
  input  logic             bclk,
  input  logic             rst_n,
  input  logic             sync,
  input  logic             codec_ready,
  input  logic             rd_valid,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [RD_W-1:0]  rd_data,
  input  logic             rec_l_valid,
  input  logic [ADC_W-1:0] rec_l,
  input  logic             rec_r_valid,
  input  logic [ADC_W-1:0] rec_r,
  output logic             sdata
);
  localparam int unsigned FRAME_W = frame_bits(TAG_W, SLOT_W, NSLOT);
  localparam int unsigned RSP_W   = IDX_W + RD_W;
  localparam int unsigned S2_HI   = FRAME_W - TAG_W - SLOT_W - 1;
  localparam int unsigned S3_LO   = FRAME_W - TAG_W - 3 * SLOT_W;
  localparam int unsigned S4_LO   = S3_LO - SLOT_W;
  localparam int unsigned RES_W   = (NSLOT - NDATA) * SLOT_W;

  logic [1:0]         rst_pipe;
  logic               rst_s;
  logic               take;
  logic               rsp_v, l_v, r_v;
  logic [RSP_W-1:0]   rsp_d;
  logic [ADC_W-1:0]   l_d, r_d;
  logic [FRAME_W-1:0] frame_w;

  // Reset asserts at once and releases on the second bit clock edge.
  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  acin_hold #(.W(RSP_W)) u_hold_rsp (
    .clk(bclk), .rst_n(rst_s), .in_v(rd_valid), .in_d({rd_idx, rd_data}),
    .take(take), .eff_v(rsp_v), .eff_d(rsp_d)
  );

  acin_hold #(.W(ADC_W)) u_hold_l (
    .clk(bclk), .rst_n(rst_s), .in_v(rec_l_valid), .in_d(rec_l),
    .take(take), .eff_v(l_v), .eff_d(l_d)
  );

  acin_hold #(.W(ADC_W)) u_hold_r (
    .clk(bclk), .rst_n(rst_s), .in_v(rec_r_valid), .in_d(rec_r),
    .take(take), .eff_v(r_v), .eff_d(r_d)
  );

  acin_frame_pack #(
    .TAG_W(TAG_W), .SLOT_W(SLOT_W), .NSLOT(NSLOT),
    .IDX_W(IDX_W), .RD_W(RD_W), .ADC_W(ADC_W)
  ) u_pack (
    .ready_i (codec_ready),
    .rd_v_i  (rsp_v),
    .rd_idx_i(rsp_d[RSP_W-1 -: IDX_W]),
    .rd_dat_i(rsp_d[RD_W-1:0]),
    .l_v_i   (l_v),
    .l_d_i   (l_d),
    .r_v_i   (r_v),
    .r_d_i   (r_d),
    .frame_o (frame_w)
  );

  acin_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk(bclk), .rst_n(rst_s), .sync_i(sync), .frame_i(frame_w),
    .start_o(take), .sdata_o(sdata)
  );

  // R3: an untagged read-data slot carries no bits
  p_slot2_zero_r3: assert property (@(posedge bclk) disable iff (!rst_s)
    !frame_w[TAG_W*0 + FRAME_W-3] |-> (frame_w[S2_HI -: SLOT_W] == '0));
  // R3: the two read-response tags always agree
  p_rsp_tags_r3: assert property (@(posedge bclk) disable iff (!rst_s)
    frame_w[FRAME_W-2] == frame_w[FRAME_W-3]);
  // R4: sample pad bits never carry data
  p_pad_zero_r4: assert property (@(posedge bclk) disable iff (!rst_s)
    (frame_w[S3_LO +: 2] == 2'b00) && (frame_w[S4_LO +: 2] == 2'b00));
  // R5: the unused slots stay at zero
  p_stuff_zero_r5: assert property (@(posedge bclk) disable iff (!rst_s)
    frame_w[RES_W-1:0] == '0);
endmodule

// File: tb/sim_acin_frame_tx.sv
module sim_acin_frame_tx;
  typedef struct packed {
    logic        rdy;
    logic        rv;
    logic [6:0]  a;
    logic [15:0] d;
    logic        lv;
    logic [17:0] l;
    logic        rvv;
    logic [17:0] r;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b1, 1'b1, 7'h7F, 16'hFFFF, 1'b1, 18'h3FFFF, 1'b1, 18'h3FFFF},
    '{1'b1, 1'b1, 7'h01, 16'h8001, 1'b1, 18'h20001, 1'b1, 18'h00001},
    '{1'b0, 1'b0, 7'h7F, 16'hFFFF, 1'b0, 18'h3FFFF, 1'b0, 18'h3FFFF},
    '{1'b1, 1'b1, 7'h2A, 16'h1234, 1'b0, 18'h3FFFF, 1'b1, 18'h15555},
    '{1'b1, 1'b0, 7'h55, 16'hA5A5, 1'b1, 18'h2AAAA, 1'b0, 18'h3FFFF},
    '{1'b0, 1'b1, 7'h40, 16'h0000, 1'b1, 18'h00000, 1'b1, 18'h3FFFE}
  };

  logic        bclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync = 1'b0;
  logic        codec_ready = 1'b0;
  logic        rd_valid = 1'b0;
  logic [6:0]  rd_idx = '0;
  logic [15:0] rd_data = '0;
  logic        rec_l_valid = 1'b0;
  logic [17:0] rec_l = '0;
  logic        rec_r_valid = 1'b0;
  logic [17:0] rec_r = '0;
  logic        sdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 bclk = ~bclk;

  acin_frame_tx u0 (
    .bclk(bclk), .rst_n(rst_n), .sync(sync), .codec_ready(codec_ready),
    .rd_valid(rd_valid), .rd_idx(rd_idx), .rd_data(rd_data),
    .rec_l_valid(rec_l_valid), .rec_l(rec_l),
    .rec_r_valid(rec_r_valid), .rec_r(rec_r), .sdata(sdata)
  );

  function automatic logic [255:0] exp_of(vec_t v);
    logic [15:0] tag;
    tag = {v.rdy, v.rv, v.rv, v.lv, v.rvv, 11'b0};
    return {tag,
            1'b0, (v.rv ? v.a : 7'h0), 12'h0,
            (v.rv ? v.d : 16'h0), 4'h0,
            (v.lv ? v.l : 18'h0), 2'b00,
            (v.rvv ? v.r : 18'h0), 2'b00,
            160'h0};
  endfunction

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    codec_ready = v.rdy;
    rd_valid    = v.rv;   rd_idx = v.a; rd_data = v.d;
    rec_l_valid = v.lv;   rec_l  = v.l;
    rec_r_valid = v.rvv;  rec_r  = v.r;
  endtask

  // Called right after a negedge at which inputs were applied and sync raised.
  task automatic capture(input bit hold, input bit inject, input vec_t b,
                         output logic [255:0] got);
    @(negedge bclk);
    rd_valid = 1'b0; rec_l_valid = 1'b0; rec_r_valid = 1'b0;
    sync = hold;
    for (int k = 0; k < 256; k++) begin
      @(negedge bclk);
      got[255-k] = sdata;
      if (inject && k == 100) apply(b);
      if (inject && k == 101) begin
        rd_valid = 1'b0; rec_l_valid = 1'b0; rec_r_valid = 1'b0;
      end
    end
  endtask

  task automatic check_frame(input logic [255:0] got, input logic [255:0] exp);
    chk("R1 whole frame", got, exp);
    chk("R2 tag slot", 256'(got[255:240]), 256'(exp[255:240]));
    chk("R3 slot1 index", 256'(got[239:220]), 256'(exp[239:220]));
    chk("R3 slot2 data", 256'(got[219:200]), 256'(exp[219:200]));
    chk("R4 slot3 left", 256'(got[199:180]), 256'(exp[199:180]));
    chk("R4 slot4 right", 256'(got[179:160]), 256'(exp[179:160]));
    chk("R5 slots 5-12", 256'(got[159:0]), 256'(exp[159:0]));
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge bclk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [255:0] got;
    vec_t a, b, z;

    // R8: line low in reset and just after release
    repeat (3) @(negedge bclk);
    chk("R8 sdata in reset", 256'(sdata), 256'(0));
    rst_n = 1'b1;
    repeat (4) @(negedge bclk);
    chk("R8 sdata after reset", 256'(sdata), 256'(0));

    // Table walk: each vector loaded as one frame
    for (int i = 0; i < 6; i++) begin
      @(negedge bclk);
      apply(VECS[i]);
      sync = 1'b1;
      capture(1'b0, 1'b0, VECS[i], got);
      check_frame(got, exp_of(VECS[i]));
    end

    // R7: idle line after the last bit
    for (int k = 0; k < 8; k++) begin
      @(negedge bclk);
      chk("R7 idle after frame", 256'(sdata), 256'(0));
    end

    // R6: mid-frame pulse held for the next frame, then cleared
    a = VECS[1];
    b = '{1'b1, 1'b1, 7'h33, 16'hC3C3, 1'b1, 18'h12345, 1'b1, 18'h2FEDC};
    z = '{1'b1, 1'b0, 7'h0, 16'h0, 1'b0, 18'h0, 1'b0, 18'h0};
    @(negedge bclk);
    apply(a);
    sync = 1'b1;
    capture(1'b0, 1'b1, b, got);
    chk("R6 running frame unchanged", got, exp_of(a));
    @(negedge bclk);
    apply(z);
    sync = 1'b1;
    capture(1'b0, 1'b0, z, got);
    chk("R6 held pulse delivered", got, exp_of(b));
    @(negedge bclk);
    apply(z);
    sync = 1'b1;
    capture(1'b0, 1'b0, z, got);
    chk("R6 held value cleared", got, exp_of(z));

    // R9: sync held high across and beyond the frame
    @(negedge bclk);
    apply(VECS[3]);
    sync = 1'b1;
    capture(1'b1, 1'b0, VECS[3], got);
    chk("R9 frame with long sync", got, exp_of(VECS[3]));
    for (int k = 0; k < 6; k++) begin
      @(negedge bclk);
      chk("R9 no restart on level", 256'(sdata), 256'(0));
    end
    sync = 1'b0;

    // R8: reset discards a held response
    @(negedge bclk);
    rd_valid = 1'b1; rd_idx = 7'h11; rd_data = 16'hBEEF;
    @(negedge bclk);
    rd_valid = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge bclk);
    chk("R8 sdata during reset", 256'(sdata), 256'(0));
    rst_n = 1'b1;
    repeat (4) @(negedge bclk);
    apply(z);
    sync = 1'b1;
    capture(1'b0, 1'b0, z, got);
    chk("R8 reset flushed held data", got, exp_of(z));

    done = 1'b1;
    summary();
    $finish;
  end
endmodule